// File: doc/BRIEF.md
# Duty-Cycled Receiver Frame Manager

This block is the control engine behind a receiver that sleeps most of the time. A slow tick input paces an off interval. When that interval ends, the receiver turns on and searches the recovered bit stream for a programmable wake-up identifier. It moves on when it finds the identifier or its bitwise complement. If the on interval runs out first, the receiver turns off again, unless a keep-on input is asserted. After the identifier, the block looks for a header word, again in either polarity. It allows a fixed number of bit periods for the header before it gives up.

Once a header is seen, every received bit goes out on a serial data line with a clock pulse. A header that arrived complemented makes every outgoing bit inverted. An end-of-message pulse stops forwarding. If the byte in progress is incomplete, zero filler bits (inverted in the complemented case) complete it. The block then reports completion with a one-cycle pulse and goes back to sleep. Two active-low override inputs act from any state. One forces the receiver off. The other forces a configuration state and outranks everything else.

Top module: `rx_frame_mgr`

## Requirements
- R1: After reset the receiver is off: rx_on, cfg_mode, spi_sck and done are all 0.
- R2: In the off state, rx_on rises on the cycle after the edge that samples the off_ticks-th tick pulse.
- R3: In identifier search, a window of the last id_len bits (first received bit is most significant) equal to id_pat or to its complement enters header search, where tick pulses no longer end the on interval.
- R4: In identifier search without a match, rx_on falls after on_ticks tick pulses; while hold_on is 1, tick pulses are not counted and rx_on stays 1.
- R5: In header search, rx_on falls on the 256th valid bit if no header match has occurred.
- R6: After a true-polarity header, each valid bit produces one spi_sck pulse with spi_dat equal to that bit, in arrival order.
- R7: After a complemented header, every spi_dat value (payload and filler) is inverted.
- R8: On eom, filler bits of value 0 (before inversion) are sent until the output bit count is a multiple of 8. Then done pulses for one cycle and rx_on is 0. No filler is sent when the count is already a multiple of 8.
- R9: While hold_off_n is 0, rx_on is 0 and no spi_sck pulse occurs. On release, the off interval restarts from zero.
- R10: While cfg_n is 0, cfg_mode is 1 and rx_on is 0, even if hold_off_n is 0. On release, the block enters the off state.
- R11: A pattern match counts only after at least id_len (or hdr_len) bits have arrived since the search state began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_n | input | 1 | Active-low force into configuration state |
| hold_off_n | input | 1 | Active-low force receiver off |
| hold_on | input | 1 | Keep receiver on during identifier search |
| tick | input | 1 | Slow interval enable pulse |
| bit_vld | input | 1 | Recovered bit valid strobe |
| bit_val | input | 1 | Recovered bit value |
| eom | input | 1 | End-of-message pulse |
| id_pat | input | 16 | Identifier pattern, low id_len bits used |
| id_len | input | 5 | Identifier length, 1 to 16 |
| hdr_pat | input | 8 | Header pattern, low hdr_len bits used |
| hdr_len | input | 4 | Header length, 1 to 8 |
| off_ticks | input | 8 | Off interval in ticks, at least 1 |
| on_ticks | input | 8 | On interval in ticks, at least 1 |
| rx_on | output | 1 | Receiver enabled |
| cfg_mode | output | 1 | Configuration state active |
| spi_sck | output | 1 | Output bit clock pulse |
| spi_dat | output | 1 | Output data bit |
| done | output | 1 | One-cycle message completion pulse |

## Verification
The bench uses an all-zero identifier. A matcher that trusted its cleared history would take the first zero as a match and never time out. It also counts exactly 255 and then 256 header-search bits, to expose an off-by-one timeout. Payloads end both on and off a byte boundary, in both polarities, and with mixed identifier and header polarities. A missing, misplaced or uninverted filler bit then shows up in the scoreboard. The bench also checks that overrides stop output mid-payload, that the keep-on input freezes the on timer, and that configuration outranks the forced-off input.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [2:0] {
    ST_CFG  = 3'd0,
    ST_OFF  = 3'd1,
    ST_IDW  = 3'd2,
    ST_HDRW = 3'd3,
    ST_DATA = 3'd4,
    ST_PAD  = 3'd5
  } rfm_state_e;
endpackage

// File: rtl/rfm_tick_cnt.sv
module rfm_tick_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expire = inc & (cnt_q == (limit - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (expire)  cnt_d = '0;
    else if (inc)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: an interval boundary restarts the count
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/rfm_pat_match.sv
module rfm_pat_match #(
  parameter int W  = 16,
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic          din,
  input  logic [W-1:0]  pat,
  input  logic [LW-1:0] len,
  output logic          hit,
  output logic          hit_inv
);
  localparam logic [LW-1:0] FULL = LW'(W);

  logic [W-1:0]  hist_q, hist_nxt, mask;
  logic [LW-1:0] fill_q, fill_nxt;
  logic          enough;

  for (genvar gi = 0; gi < W; gi++) begin : g_mask
    assign mask[gi] = (gi < int'(len));
  end

  assign hist_nxt = {hist_q[W-2:0], din};
  assign fill_nxt = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
  assign enough   = (fill_nxt >= len);
  assign hit      = shift & enough & ~|((hist_nxt ^ pat) & mask);
  assign hit_inv  = shift & enough & ~|((hist_nxt ^ ~pat) & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift) begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end

  // R11: an empty history never yields a multi-bit match
  a_r11_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0 && len > 1) |-> (!hit && !hit_inv));
endmodule

// File: rtl/rfm_shift_out.sv
module rfm_shift_out #(
  parameter int BYTE_W = 8,
  parameter int BW     = $clog2(BYTE_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic data_en,
  input  logic data_bit,
  input  logic pad_en,
  input  logic inv,
  output logic sck,
  output logic dat,
  output logic aligned_nxt,
  output logic pad_last
);
  localparam logic [BW-1:0] LAST = BW'(BYTE_W - 1);

  logic          sck_q, dat_q, phase_q;
  logic [BW-1:0] cnt_q, cnt_nxt;
  logic          emit, val;

  assign emit        = data_en | (pad_en & phase_q);
  assign val         = data_en ? data_bit : 1'b0;
  assign cnt_nxt     = !emit ? cnt_q : ((cnt_q == LAST) ? '0 : cnt_q + 1'b1);
  assign aligned_nxt = (cnt_nxt == '0);
  assign pad_last    = pad_en & phase_q & (cnt_q == LAST);
  assign sck         = sck_q;
  assign dat         = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      dat_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sck_q   <= emit;
      phase_q <= pad_en ? ~phase_q : 1'b0;
      if (emit) dat_q <= val ^ inv;
      if (clr)  cnt_q <= '0;
      else      cnt_q <= cnt_nxt;
    end
  end

  // R8: filler clock pulses are separated by an idle cycle
  a_r8_pad_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_en && sck_q) |=> !sck_q);
endmodule

// File: rtl/rx_frame_mgr.sv
module rx_frame_mgr
  import rfm_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int HDR_W    = 8,
  parameter int TW       = 8,
  parameter int TMO_BITS = 256,
  parameter int BYTE_W   = 8,
  localparam int IDL_W   = $clog2(ID_W + 1),
  localparam int HDL_W   = $clog2(HDR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_n,
  input  logic             hold_off_n,
  input  logic             hold_on,
  input  logic             tick,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             eom,
  input  logic [ID_W-1:0]  id_pat,
  input  logic [IDL_W-1:0] id_len,
  input  logic [HDR_W-1:0] hdr_pat,
  input  logic [HDL_W-1:0] hdr_len,
  input  logic [TW-1:0]    off_ticks,
  input  logic [TW-1:0]    on_ticks,
  output logic             rx_on,
  output logic             cfg_mode,
  output logic             spi_sck,
  output logic             spi_dat,
  output logic             done
);
  localparam int TMO_W = $clog2(TMO_BITS + 1);
  localparam int CW    = (TW > TMO_W) ? TW : TMO_W;

  rfm_state_e    st_q, st_d;
  logic          inv_q, done_q, done_d;
  logic          cnt_inc, cnt_clr, cnt_exp;
  logic [CW-1:0] cnt_lim;
  logic          id_hit, id_hit_inv, hdr_hit, hdr_hit_inv;
  logic          st_chg, aligned_nxt, pad_last;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_CFG:  st_d = ST_OFF;
      ST_OFF:  if (cnt_exp) st_d = ST_IDW;
      ST_IDW: begin
        if (id_hit || id_hit_inv) st_d = ST_HDRW;
        else if (cnt_exp)         st_d = ST_OFF;
      end
      ST_HDRW: begin
        if (hdr_hit || hdr_hit_inv) st_d = ST_DATA;
        else if (cnt_exp)           st_d = ST_OFF;
      end
      ST_DATA: begin
        if (eom) begin
          if (aligned_nxt) begin
            st_d   = ST_OFF;
            done_d = 1'b1;
          end else begin
            st_d = ST_PAD;
          end
        end
      end
      ST_PAD: begin
        if (pad_last) begin
          st_d   = ST_OFF;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (!hold_off_n) begin
      st_d   = ST_OFF;
      done_d = 1'b0;
    end
    if (!cfg_n) begin
      st_d   = ST_CFG;
      done_d = 1'b0;
    end
  end

  // interval / timeout counter selection
  always_comb begin
    cnt_inc = 1'b0;
    cnt_lim = CW'(TMO_BITS);
    unique case (st_q)
      ST_OFF: begin
        cnt_inc = tick;
        cnt_lim = CW'(off_ticks);
      end
      ST_IDW: begin
        cnt_inc = tick & ~hold_on;
        cnt_lim = CW'(on_ticks);
      end
      ST_HDRW: begin
        cnt_inc = bit_vld;
        cnt_lim = CW'(TMO_BITS);
      end
      default: cnt_inc = 1'b0;
    endcase
  end

  assign st_chg  = (st_d != st_q);
  assign cnt_clr = st_chg | ~hold_off_n | ~cfg_n;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      inv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (st_q == ST_HDRW && st_d == ST_DATA) inv_q <= ~hdr_hit;
    end
  end

  rfm_tick_cnt #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .limit  (cnt_lim),
    .expire (cnt_exp)
  );

  rfm_pat_match #(.W(ID_W), .LW(IDL_W)) u_id (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_chg),
    .shift   ((st_q == ST_IDW) & bit_vld),
    .din     (bit_val),
    .pat     (id_pat),
    .len     (id_len),
    .hit     (id_hit),
    .hit_inv (id_hit_inv)
  );

  rfm_pat_match #(.W(HDR_W), .LW(HDL_W)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_chg),
    .shift   ((st_q == ST_HDRW) & bit_vld),
    .din     (bit_val),
    .pat     (hdr_pat),
    .len     (hdr_len),
    .hit     (hdr_hit),
    .hit_inv (hdr_hit_inv)
  );

  rfm_shift_out #(.BYTE_W(BYTE_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (st_d == ST_DATA && st_q != ST_DATA),
    .data_en     ((st_q == ST_DATA) & bit_vld & hold_off_n & cfg_n),
    .data_bit    (bit_val),
    .pad_en      ((st_q == ST_PAD) & hold_off_n & cfg_n),
    .inv         (inv_q),
    .sck         (spi_sck),
    .dat         (spi_dat),
    .aligned_nxt (aligned_nxt),
    .pad_last    (pad_last)
  );

  assign rx_on    = (st_q == ST_IDW) || (st_q == ST_HDRW) ||
                    (st_q == ST_DATA) || (st_q == ST_PAD);
  assign cfg_mode = (st_q == ST_CFG);
  assign done     = done_q;

  // R9: forced-off input turns the receiver off on the next cycle
  a_r9_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_off_n |=> !rx_on);
  // R10: configuration request wins over everything
  a_r10_cfg_prio: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n |=> (cfg_mode && !rx_on));
  // R8: completion is reported with the receiver already off
  a_r8_done_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_on);
  // R7: polarity is fixed for the whole payload
  a_r7_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |=> ((st_q != ST_DATA) || $stable(inv_q)));
  // R4: keep-on holds identifier search open
  a_r4_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDW && hold_on && hold_off_n && cfg_n) |=> rx_on);
endmodule

// File: tb/sim_rx_frame_mgr.sv
`timescale 1ns/1ps
module sim_rx_frame_mgr;
  logic        clk, rst_n, cfg_n, hold_off_n, hold_on, tick;
  logic        bit_vld, bit_val, eom;
  logic [15:0] id_pat;
  logic [4:0]  id_len;
  logic [7:0]  hdr_pat;
  logic [3:0]  hdr_len;
  logic [7:0]  off_ticks, on_ticks;
  logic        rx_on, cfg_mode, spi_sck, spi_dat, done;

  int n_chk = 0;
  int n_err = 0;
  bit exp_q[$];

  localparam logic [15:0] ID  = 16'hA5C3;
  localparam logic [7:0]  HDR = 8'h6E;

  rx_frame_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .hold_off_n(hold_off_n),
    .hold_on(hold_on), .tick(tick), .bit_vld(bit_vld), .bit_val(bit_val),
    .eom(eom), .id_pat(id_pat), .id_len(id_len), .hdr_pat(hdr_pat),
    .hdr_len(hdr_len), .off_ticks(off_ticks), .on_ticks(on_ticks),
    .rx_on(rx_on), .cfg_mode(cfg_mode), .spi_sck(spi_sck),
    .spi_dat(spi_dat), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: compare each output bit with the scoreboard
  always @(negedge clk) begin
    if (rst_n && spi_sck) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R9 unexpected spi_sck", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(spi_dat == e, "R6/R7/R8 spi_dat", int'(spi_dat), int'(e));
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic tick_pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic bit_send(input bit b);
    bit_val = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic word_send(input logic [15:0] w, input int len, input bit inv);
    for (int i = len - 1; i >= 0; i--) bit_send(w[i] ^ inv);
  endtask

  task automatic wake();
    for (int i = 0; i < int'(off_ticks); i++) tick_pulse();
    check(rx_on == 1'b1, "R2 wake", int'(rx_on), 1);
  endtask

  task automatic payload(input logic [15:0] w, input int n, input bit inv);
    for (int i = n - 1; i >= 0; i--) begin
      exp_q.push_back(w[i] ^ inv);
      bit_send(w[i]);
    end
  endtask

  task automatic finish_msg(input int n, input bit inv);
    int pad;
    bit seen;
    pad = (8 - (n % 8)) % 8;
    for (int i = 0; i < pad; i++) exp_q.push_back(inv);
    eom = 1'b1;
    @(negedge clk);
    eom = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(seen, "R8 done pulse", int'(seen), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    check(rx_on == 1'b0, "R8 off after done", int'(rx_on), 0);
    check(exp_q.size() == 0, "R8 filler count", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_n = 1'b1; hold_off_n = 1'b1; hold_on = 1'b0;
    tick = 1'b0; bit_vld = 1'b0; bit_val = 1'b0; eom = 1'b0;
    id_pat = 16'h0000; id_len = 5'd16; hdr_pat = HDR; hdr_len = 4'd8;
    off_ticks = 8'd3; on_ticks = 8'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rx_on == 1'b0, "R1 rx_on", int'(rx_on), 0);
    check(cfg_mode == 1'b0, "R1 cfg_mode", int'(cfg_mode), 0);
    check(spi_sck == 1'b0, "R1 spi_sck", int'(spi_sck), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);

    // R2 off interval boundary
    tick_pulse(); tick_pulse();
    check(rx_on == 1'b0, "R2 early", int'(rx_on), 0);
    tick_pulse();
    check(rx_on == 1'b1, "R2 on", int'(rx_on), 1);

    // R11 all-zero identifier, 15 bits must not match
    for (int i = 0; i < 15; i++) bit_send(1'b0);
    for (int i = 0; i < 4; i++) tick_pulse();
    check(rx_on == 1'b0, "R11 partial fill", int'(rx_on), 0);

    // R3 then R5: 16 zeros match, header search ignores ticks
    wake();
    for (int i = 0; i < 16; i++) bit_send(1'b0);
    for (int i = 0; i < 4; i++) tick_pulse();
    check(rx_on == 1'b1, "R3 header search", int'(rx_on), 1);
    for (int i = 0; i < 255; i++) bit_send(1'b0);
    check(rx_on == 1'b1, "R5 bit 255", int'(rx_on), 1);
    bit_send(1'b0);
    check(rx_on == 1'b0, "R5 bit 256", int'(rx_on), 0);

    // R4 on-interval expiry and keep-on
    id_pat = ID;
    wake();
    for (int i = 0; i < 3; i++) tick_pulse();
    check(rx_on == 1'b1, "R4 before expiry", int'(rx_on), 1);
    tick_pulse();
    check(rx_on == 1'b0, "R4 expiry", int'(rx_on), 0);
    wake();
    hold_on = 1'b1;
    for (int i = 0; i < 8; i++) tick_pulse();
    check(rx_on == 1'b1, "R4 hold_on", int'(rx_on), 1);
    hold_on = 1'b0;
    for (int i = 0; i < 3; i++) tick_pulse();
    check(rx_on == 1'b1, "R4 after release", int'(rx_on), 1);
    tick_pulse();
    check(rx_on == 1'b0, "R4 expiry after release", int'(rx_on), 0);

    // R6 true polarity, aligned end, noise before identifier
    wake();
    bit_send(1'b0); bit_send(1'b1); bit_send(1'b1);
    word_send(ID, 16, 1'b0);
    word_send({8'h00, HDR}, 8, 1'b0);
    payload(16'hB41F, 16, 1'b0);
    finish_msg(16, 1'b0);

    // R7 complemented header, 11 bits, filler inverted
    wake();
    word_send(ID, 16, 1'b1);
    word_send({8'h00, HDR}, 8, 1'b1);
    payload(16'h05A7, 11, 1'b1);
    finish_msg(11, 1'b1);

    // R3 complemented identifier with true header, R8 zero filler
    wake();
    word_send(ID, 16, 1'b1);
    word_send({8'h00, HDR}, 8, 1'b0);
    payload(16'h0005, 3, 1'b0);
    finish_msg(3, 1'b0);

    // R9 forced off during header search
    wake();
    word_send(ID, 16, 1'b0);
    bit_send(1'b0); bit_send(1'b1); bit_send(1'b1);
    hold_off_n = 1'b0;
    @(negedge clk);
    check(rx_on == 1'b0, "R9 forced off", int'(rx_on), 0);
    for (int i = 0; i < 5; i++) tick_pulse();
    check(rx_on == 1'b0, "R9 held off", int'(rx_on), 0);
    hold_off_n = 1'b1;
    tick_pulse(); tick_pulse();
    check(rx_on == 1'b0, "R9 restart count", int'(rx_on), 0);
    tick_pulse();
    check(rx_on == 1'b1, "R9 wake after release", int'(rx_on), 1);

    // R9 forced off during payload: no further output
    word_send(ID, 16, 1'b0);
    word_send({8'h00, HDR}, 8, 1'b0);
    payload(16'h000A, 4, 1'b0);
    hold_off_n = 1'b0;
    @(negedge clk);
    check(rx_on == 1'b0, "R9 off in payload", int'(rx_on), 0);
    bit_send(1'b1);
    eom = 1'b1;
    @(negedge clk);
    eom = 1'b0;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 no output", exp_q.size(), 0);
    hold_off_n = 1'b1;

    // R10 configuration priority
    wake();
    cfg_n = 1'b0;
    hold_off_n = 1'b0;
    @(negedge clk);
    check(cfg_mode == 1'b1, "R10 cfg_mode", int'(cfg_mode), 1);
    check(rx_on == 1'b0, "R10 rx_on", int'(rx_on), 0);
    for (int i = 0; i < 5; i++) tick_pulse();
    check(cfg_mode == 1'b1 && rx_on == 1'b0, "R10 held", int'(rx_on), 0);
    cfg_n = 1'b1;
    @(negedge clk);
    check(cfg_mode == 1'b0, "R10 release", int'(cfg_mode), 0);
    hold_off_n = 1'b1;
    wake();

    repeat (4) @(negedge clk);
    summary();
  end
endmodule